// File: doc/BRIEF.md
# Address Decoder with Per-Region Wait Timing

This block sits between a processor's single request port and a set of memories. Each request carries a 28-bit address, a transfer size, a write flag and a flag saying whether the access follows on from the previous one. The top four address bits pick one of nine regions: boot code, slow work RAM, fast work RAM, control registers, colour table, picture memory, sprite table, cartridge ROM and save RAM. Every other four-bit slot is unmapped. Inside a region, the offset wraps at the region size.

Each region has a fixed data path width and its own wait timing. The block holds a one-hot select on the chosen region, counts the wait cycles, and then pulses a ready strobe that carries the read data. A 32-bit access to a 16-bit region runs as two halfword transfers. Any access to the 8-bit save RAM runs as one byte transfer. Cartridge ROM is reached through three address windows, each with its own wait counts for random and follow-on accesses. A read of the boot code returns a fixed substitute word unless the processor is itself fetching instructions from the boot code.

Top module: `busmap_wait_ctrl`

## Requirements
- R1: Address slot `req_addr[27:24]` decodes as follows:
  - 0 to boot code, with offset bits [13:0].
  - 2 to slow RAM, with offset bits [17:0].
  - 3 to fast RAM, with offset bits [14:0].
  - 4 to control registers, only when bits [23:10] are zero (offset [9:0]).
  - 5 to the colour table and 7 to the sprite table, each with offset [9:0].
  - 6 to picture memory. Its offset is bits [16:0], minus 0x8000 when bits [16:15] are both 1.
  - 8 to 13 to cartridge ROM, with offset [24:0].
  - 14 to save RAM, with offset [15:0].
- R2: `mem_sel` is one-hot while a transfer runs and zero otherwise. The bit order, from bit 0, is: boot, slow RAM, fast RAM, control, colour, picture, sprite, cartridge, save.
- R3: Boot code, fast RAM and control registers have zero waits. `resp_ready` is high in the cycle that begins one clock edge after the accepting edge.
- R4: Slow RAM inserts 2 wait cycles per transfer, or 1 when `xram_fast` is high. A transfer with w waits ends w+1 edges after it starts.
- R5: The colour, picture and sprite regions insert 1 wait when `disp_busy` is high at the start of a transfer, and 0 when it is low.
- R6: Cartridge windows are chosen by the address slot: 8–9 is window 0, 10–11 is window 1, 12–13 is window 2. In `wait_cfg`, window m takes its random-access count from bits [4m+1:4m] and its follow-on count from bits [4m+3:4m+2]. `req_seq`=1 selects the follow-on count.
- R7: A word access (`req_size`=2) to a 16-bit region runs as two halfword transfers:
  - The offset is first aligned down to 4. The first transfer goes to that offset and the second to offset+2.
  - The second transfer always uses follow-on timing.
  - Write data goes out as bits [15:0] and then bits [31:16], each on `mem_wdata[15:0]`.
  - Read data is {second[15:0], first[15:0]}.
  - Sizes are 0=byte, 1=half, 2=word. Narrow memory data arrives on the low lanes.
- R8: Save RAM accesses of any size run as a single byte transfer (`mem_size`=0) at the exact addressed byte. The wait count comes from `wait_cfg[13:12]`.
- R9: A boot-code read returns `BOOT_SUBST` unless `fetch_addr` is below 0x4000.
- R10: An unmapped address raises `resp_err` with `resp_rdata`=0 and never drives `mem_sel`. `resp_ready` is high in the cycle right after the accepting edge.
- R11: `resp_ready` is a one-cycle pulse. A `req_valid` that arrives while an access is in flight is ignored.
- R12: After reset, `resp_ready`, `resp_err` and `mem_sel` are all zero.
- R13: Halfword accesses clear offset bit 0. Read data narrower than a word is zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 28 | Request address |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_write | input | 1 | 1 for write |
| req_seq | input | 1 | Follow-on access flag |
| req_wdata | input | 32 | Write data |
| fetch_addr | input | 28 | Current instruction fetch address |
| disp_busy | input | 1 | Display is reading video memories now |
| xram_fast | input | 1 | Cut slow RAM waits to 1 |
| wait_cfg | input | 14 | Cartridge window and save RAM wait counts |
| mem_rdata | input | 32 | Read data from the selected memory |
| mem_sel | output | 9 | One-hot region select |
| mem_addr | output | 25 | Offset inside the region |
| mem_size | output | 2 | Size of the current transfer |
| mem_we | output | 1 | Write enable of the current transfer |
| mem_wdata | output | 32 | Write data of the current transfer |
| resp_ready | output | 1 | Completion pulse |
| resp_err | output | 1 | Unmapped address flag, valid with ready |
| resp_rdata | output | 32 | Read data, valid with ready |

## Verification
The assertions assume that `mem_rdata` depends only on the current transfer. They also assume that `disp_busy`, `xram_fast` and `wait_cfg` matter only when a transfer starts, and that `req_size` never takes the value 3. The stimulus respects these assumptions:
- The bench changes configuration inputs only while the block is idle.
- A memory model in the bench derives read data from `mem_addr` alone.
- The bench uses only sizes 0 to 2.
- Requests are driven on the falling edge and held for one cycle. The only exception is the scenario that deliberately presses `req_valid` during a long cartridge access.

// File: rtl/busmap_pkg.sv
package busmap_pkg;

  typedef enum logic [3:0] {
    RG_BOOT  = 4'd0,
    RG_XRAM  = 4'd1,
    RG_IRAM  = 4'd2,
    RG_IOREG = 4'd3,
    RG_PAL   = 4'd4,
    RG_VID   = 4'd5,
    RG_OBJ   = 4'd6,
    RG_CART  = 4'd7,
    RG_SAVE  = 4'd8,
    RG_NONE  = 4'd9
  } region_e;

  localparam int unsigned N_REGION = 9;
  localparam int unsigned WIN_W    = 2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // data path width code of a region: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit
  function automatic logic [1:0] path_code(region_e r);
    case (r)
      RG_XRAM, RG_PAL, RG_VID, RG_CART: path_code = 2'd1;
      RG_SAVE:                          path_code = 2'd0;
      default:                          path_code = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/busmap_decode.sv
module busmap_decode
  import busmap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 28,
  parameter int unsigned OFF_W   = 25,
  parameter int unsigned BOOT_AW = 14,
  parameter int unsigned XRAM_AW = 18,
  parameter int unsigned IRAM_AW = 15,
  parameter int unsigned IO_AW   = 10,
  parameter int unsigned PAL_AW  = 10,
  parameter int unsigned VID_AW  = 17,
  parameter int unsigned OBJ_AW  = 10,
  parameter int unsigned SAVE_AW = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [WIN_W-1:0]  win,
  output logic [OFF_W-1:0]  offset
);
  localparam int unsigned SLOT_W  = 4;
  localparam int unsigned INNER_W = ADDR_W - SLOT_W;
  localparam logic [VID_AW-1:0] VID_FOLD = VID_AW'(1) << (VID_AW - 2);

  logic [SLOT_W-1:0]  slot;
  logic [INNER_W-1:0] inner;
  logic [VID_AW-1:0]  vid_raw;

  assign slot    = addr[ADDR_W-1 -: SLOT_W];
  assign inner   = addr[INNER_W-1:0];
  assign vid_raw = addr[VID_AW-1:0];

  always_comb begin
    region = RG_NONE;
    win    = '0;
    offset = '0;
    case (slot)
      4'h0: begin region = RG_BOOT; offset = OFF_W'(addr[BOOT_AW-1:0]); end
      4'h2: begin region = RG_XRAM; offset = OFF_W'(addr[XRAM_AW-1:0]); end
      4'h3: begin region = RG_IRAM; offset = OFF_W'(addr[IRAM_AW-1:0]); end
      4'h4: begin
        if ((inner >> IO_AW) == '0) begin
          region = RG_IOREG;
          offset = OFF_W'(addr[IO_AW-1:0]);
        end
      end
      4'h5: begin region = RG_PAL; offset = OFF_W'(addr[PAL_AW-1:0]); end
      4'h6: begin
        region = RG_VID;
        // top quarter of the slot folds back onto the quarter below it
        if (vid_raw[VID_AW-1 -: 2] == 2'b11) offset = OFF_W'(vid_raw - VID_FOLD);
        else                                 offset = OFF_W'(vid_raw);
      end
      4'h7: begin region = RG_OBJ; offset = OFF_W'(addr[OBJ_AW-1:0]); end
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: begin
        region = RG_CART;
        win    = slot[2:1];
        offset = OFF_W'(addr[OFF_W-1:0]);
      end
      4'hE: begin region = RG_SAVE; offset = OFF_W'(addr[SAVE_AW-1:0]); end
      default: region = RG_NONE;
    endcase
  end

endmodule

// File: rtl/busmap_wait.sv
module busmap_wait
  import busmap_pkg::*;
#(
  parameter int unsigned WAIT_W = 2,
  parameter int unsigned N_WIN  = 3,
  localparam int unsigned CFG_W = (2 * N_WIN + 1) * WAIT_W
) (
  input  region_e            region,
  input  logic [WIN_W-1:0]   win,
  input  logic               seq,
  input  logic               disp_busy,
  input  logic               xram_fast,
  input  logic [CFG_W-1:0]   wait_cfg,
  output logic [WAIT_W-1:0]  waits
);
  logic [WAIT_W-1:0] rand_cnt [N_WIN];
  logic [WAIT_W-1:0] next_cnt [N_WIN];
  logic [WAIT_W-1:0] save_cnt;
  logic [WAIT_W-1:0] cart_cnt;

  for (genvar m = 0; m < N_WIN; m++) begin : g_win
    assign rand_cnt[m] = wait_cfg[(2*m)*WAIT_W +: WAIT_W];
    assign next_cnt[m] = wait_cfg[(2*m+1)*WAIT_W +: WAIT_W];
  end

  assign save_cnt = wait_cfg[2*N_WIN*WAIT_W +: WAIT_W];

  always_comb begin
    cart_cnt = '0;
    for (int m = 0; m < N_WIN; m++) begin
      if (win == WIN_W'(m)) cart_cnt = seq ? next_cnt[m] : rand_cnt[m];
    end
  end

  always_comb begin
    case (region)
      RG_XRAM:               waits = xram_fast ? WAIT_W'(1) : WAIT_W'(2);
      RG_PAL, RG_VID, RG_OBJ: waits = disp_busy ? WAIT_W'(1) : WAIT_W'(0);
      RG_CART:               waits = cart_cnt;
      RG_SAVE:               waits = save_cnt;
      default:               waits = '0;
    endcase
  end

endmodule

// File: rtl/busmap_seq.sv
module busmap_seq
  import busmap_pkg::*;
#(
  parameter int unsigned OFF_W      = 25,
  parameter int unsigned WAIT_W     = 2,
  parameter logic [31:0] BOOT_SUBST = 32'h0BAD_B105
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_seq,
  input  logic [1:0]          req_size,
  input  logic [31:0]         req_wdata,
  input  logic                fetch_boot,
  input  region_e             dec_region,
  input  logic [WIN_W-1:0]    dec_win,
  input  logic [OFF_W-1:0]    dec_off,
  input  logic [WAIT_W-1:0]   wait_in,
  input  logic [31:0]         mem_rdata,
  output region_e             wc_region,
  output logic [WIN_W-1:0]    wc_win,
  output logic                wc_seq,
  output logic [N_REGION-1:0] mem_sel,
  output logic [OFF_W-1:0]    mem_addr,
  output logic [1:0]          mem_size,
  output logic                mem_we,
  output logic [31:0]         mem_wdata,
  output logic                resp_ready,
  output logic                resp_err,
  output logic [31:0]         resp_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_RESP} state_e;

  state_e            state_q;
  region_e           rg_q;
  logic [WIN_W-1:0]  win_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              we_q, split_q, part_q, guard_q, err_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [31:0]       wdata_q, rdata_q;
  logic [15:0]       lo_q;

  logic              accept;
  logic [1:0]        pc, eff_size, req_sz;
  logic              eff_split;
  logic [OFF_W-1:0]  eff_off;
  logic [31:0]       rd_final;

  assign accept = (state_q == S_IDLE) && req_valid;
  assign req_sz = (req_size == 2'd3) ? SZ_WORD : req_size;
  assign pc     = path_code(dec_region);

  always_comb begin
    eff_split = 1'b0;
    if (pc == 2'd0) begin
      eff_size = SZ_BYTE;
    end else if (pc == 2'd1 && req_sz == SZ_WORD) begin
      eff_size  = SZ_HALF;
      eff_split = 1'b1;
    end else begin
      eff_size = req_sz;
    end
    eff_off = dec_off;
    if (eff_split || eff_size == SZ_WORD) eff_off[1:0] = 2'b00;
    else if (eff_size == SZ_HALF)         eff_off[0]   = 1'b0;
  end

  // wait lookup: decoded request when idle, held region for the second half
  assign wc_region = (state_q == S_IDLE) ? dec_region : rg_q;
  assign wc_win    = (state_q == S_IDLE) ? dec_win    : win_q;
  assign wc_seq    = (state_q == S_IDLE) ? req_seq    : 1'b1;

  always_comb begin
    if (we_q)                         rd_final = '0;
    else if (guard_q)                 rd_final = BOOT_SUBST;
    else if (split_q)                 rd_final = {mem_rdata[15:0], lo_q};
    else if (size_q == SZ_BYTE)       rd_final = {24'h0, mem_rdata[7:0]};
    else if (size_q == SZ_HALF)       rd_final = {16'h0, mem_rdata[15:0]};
    else                              rd_final = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      rg_q    <= RG_NONE;
      win_q   <= '0;
      off_q   <= '0;
      size_q  <= SZ_BYTE;
      we_q    <= 1'b0;
      split_q <= 1'b0;
      part_q  <= 1'b0;
      guard_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            rg_q    <= dec_region;
            win_q   <= dec_win;
            off_q   <= eff_off;
            size_q  <= eff_size;
            we_q    <= req_write;
            split_q <= eff_split;
            part_q  <= 1'b0;
            wdata_q <= req_wdata;
            cnt_q   <= wait_in;
            guard_q <= (dec_region == RG_BOOT) && !req_write && !fetch_boot;
            rdata_q <= '0;
            if (dec_region == RG_NONE) begin
              err_q   <= 1'b1;
              state_q <= S_RESP;
            end else begin
              err_q   <= 1'b0;
              state_q <= S_XFER;
            end
          end
        end
        S_XFER: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (split_q && !part_q) begin
            lo_q   <= mem_rdata[15:0];
            part_q <= 1'b1;
            cnt_q  <= wait_in;
          end else begin
            rdata_q <= rd_final;
            state_q <= S_RESP;
          end
        end
        default: begin
          state_q <= S_IDLE;
          err_q   <= 1'b0;
        end
      endcase
    end
  end

  for (genvar i = 0; i < N_REGION; i++) begin : g_sel
    assign mem_sel[i] = (state_q == S_XFER) && (rg_q == region_e'(i));
  end

  assign mem_addr   = off_q + {{(OFF_W-2){1'b0}}, part_q, 1'b0};
  assign mem_size   = size_q;
  assign mem_we     = we_q && (state_q == S_XFER);
  assign mem_wdata  = part_q ? {16'h0, wdata_q[31:16]} : wdata_q;
  assign resp_ready = (state_q == S_RESP);
  assign resp_err   = err_q && (state_q == S_RESP);
  assign resp_rdata = (state_q == S_RESP) ? rdata_q : '0;

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_sel));

  p_fast_single_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_sel[RG_BOOT] || mem_sel[RG_IRAM] || mem_sel[RG_IOREG]) |=> (mem_sel == '0));

  p_hold_addr_r7: assert property (@(posedge clk) disable iff (rst)
    ((mem_sel != '0) && cnt_q != '0) |=> $stable(mem_addr));

  p_save_byte_r8: assert property (@(posedge clk) disable iff (rst)
    mem_sel[RG_SAVE] |-> (mem_size == SZ_BYTE));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (resp_rdata == '0 && mem_sel == '0 && resp_ready));

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    resp_ready |=> !resp_ready);

endmodule

// File: rtl/busmap_wait_ctrl.sv
module busmap_wait_ctrl
  import busmap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 28,
  parameter int unsigned OFF_W      = 25,
  parameter int unsigned WAIT_W     = 2,
  parameter int unsigned N_WIN      = 3,
  parameter int unsigned BOOT_AW    = 14,
  parameter logic [31:0] BOOT_SUBST = 32'h0BAD_B105,
  localparam int unsigned CFG_W     = (2 * N_WIN + 1) * WAIT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic                req_seq,
  input  logic [31:0]         req_wdata,
  input  logic [ADDR_W-1:0]   fetch_addr,
  input  logic                disp_busy,
  input  logic                xram_fast,
  input  logic [CFG_W-1:0]    wait_cfg,
  input  logic [31:0]         mem_rdata,
  output logic [N_REGION-1:0] mem_sel,
  output logic [OFF_W-1:0]    mem_addr,
  output logic [1:0]          mem_size,
  output logic                mem_we,
  output logic [31:0]         mem_wdata,
  output logic                resp_ready,
  output logic                resp_err,
  output logic [31:0]         resp_rdata
);
  localparam logic [ADDR_W-1:0] BOOT_END = ADDR_W'(1) << BOOT_AW;

  region_e           dec_region, wc_region;
  logic [WIN_W-1:0]  dec_win, wc_win;
  logic [OFF_W-1:0]  dec_off;
  logic              wc_seq, fetch_boot;
  logic [WAIT_W-1:0] waits;

  assign fetch_boot = (fetch_addr < BOOT_END);

  busmap_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BOOT_AW(BOOT_AW)) u_decode (
    .addr   (req_addr),
    .region (dec_region),
    .win    (dec_win),
    .offset (dec_off)
  );

  busmap_wait #(.WAIT_W(WAIT_W), .N_WIN(N_WIN)) u_wait (
    .region    (wc_region),
    .win       (wc_win),
    .seq       (wc_seq),
    .disp_busy (disp_busy),
    .xram_fast (xram_fast),
    .wait_cfg  (wait_cfg),
    .waits     (waits)
  );

  busmap_seq #(.OFF_W(OFF_W), .WAIT_W(WAIT_W), .BOOT_SUBST(BOOT_SUBST)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_seq    (req_seq),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .fetch_boot (fetch_boot),
    .dec_region (dec_region),
    .dec_win    (dec_win),
    .dec_off    (dec_off),
    .wait_in    (waits),
    .mem_rdata  (mem_rdata),
    .wc_region  (wc_region),
    .wc_win     (wc_win),
    .wc_seq     (wc_seq),
    .mem_sel    (mem_sel),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .resp_ready (resp_ready),
    .resp_err   (resp_err),
    .resp_rdata (resp_rdata)
  );

  p_reset_quiet_r12: assert property (@(posedge clk)
    $past(rst) |-> (!resp_ready && mem_sel == '0));

endmodule

// File: tb/busmap_wait_ctrl_tb.sv
module busmap_wait_ctrl_tb;
  localparam logic [31:0] SUBST = 32'h0BAD_B105;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [27:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_seq = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [27:0] fetch_addr = 28'h8000000;
  logic        disp_busy = 1'b0;
  logic        xram_fast = 1'b0;
  logic [13:0] wait_cfg = '0;
  logic [31:0] mem_rdata;
  logic [8:0]  mem_sel;
  logic [24:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic        resp_ready, resp_err;
  logic [31:0] resp_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  // memory model: data derived from the offset only, narrow data on low lanes
  assign mem_rdata = {mem_addr[15:0] ^ 16'hC3C3, mem_addr[15:0] ^ 16'h5A5A};

  busmap_wait_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_seq(req_seq),
    .req_wdata(req_wdata), .fetch_addr(fetch_addr), .disp_busy(disp_busy),
    .xram_fast(xram_fast), .wait_cfg(wait_cfg), .mem_rdata(mem_rdata),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .resp_ready(resp_ready),
    .resp_err(resp_err), .resp_rdata(resp_rdata)
  );

  function automatic logic [31:0] ew(input logic [24:0] off);
    return {off[15:0] ^ 16'hC3C3, off[15:0] ^ 16'h5A5A};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int          lat;
  logic [31:0] rd;
  logic        err;
  logic [8:0]  f_sel;
  logic [24:0] f_addr, l_addr;
  logic [1:0]  f_size;
  logic [31:0] f_wd, l_wd;
  int          sel_cyc;
  logic        saw_we;

  task automatic do_req(input logic [27:0] a, input logic [1:0] sz, input logic we,
                        input logic sq, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = we;
    req_seq = sq; req_wdata = wd;
    @(posedge clk);
    lat = 0; sel_cyc = 0; f_sel = '0; saw_we = 1'b0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (resp_ready) break;
      if (mem_sel != '0) begin
        if (sel_cyc == 0) begin
          f_sel = mem_sel; f_addr = mem_addr; f_size = mem_size; f_wd = mem_wdata;
        end
        l_addr = mem_addr; l_wd = mem_wdata;
        saw_we = saw_we | mem_we;
        sel_cyc++;
      end
      @(posedge clk);
      lat++;
      if (lat > 50) break;
    end
    rd = resp_rdata; err = resp_err;
    @(negedge clk);
    chk(!resp_ready, "R11 ready pulse", 32'(resp_ready), 0);
  endtask

  task automatic t_reset;
    chk(!resp_ready && !resp_err, "R12 reset resp", {resp_ready, resp_err}, 0);
    chk(mem_sel == '0, "R12 reset sel", 32'(mem_sel), 0);
  endtask

  task automatic t_zero_wait;
    fetch_addr = 28'h0000100;
    do_req(28'h3008010, 2, 0, 0, 0);
    chk(lat == 1, "R3 iram latency", lat, 1);
    chk(f_sel == 9'h004 && f_addr == 25'h10, "R1 iram mirror", {f_sel, 23'(f_addr)}, {9'h004, 23'h10});
    chk(rd == ew(25'h10), "R3 iram data", rd, ew(25'h10));
    do_req(28'h40003FC, 2, 0, 0, 0);
    chk(lat == 1 && f_sel == 9'h008 && !err, "R1 io top", lat, 1);
  endtask

  task automatic t_boot_guard;
    fetch_addr = 28'h0000100;
    do_req(28'h0004104, 2, 0, 0, 0);
    chk(rd == ew(25'h104) && f_sel == 9'h001, "R9 boot open read", rd, ew(25'h104));
    fetch_addr = 28'h8000000;
    do_req(28'h0000104, 2, 0, 0, 0);
    chk(rd == SUBST, "R9 boot guarded", rd, SUBST);
    fetch_addr = 28'h0004000;
    do_req(28'h0000104, 2, 0, 0, 0);
    chk(rd == SUBST, "R9 fetch just outside", rd, SUBST);
    fetch_addr = 28'h8000000;
  endtask

  task automatic t_xram;
    xram_fast = 0;
    do_req(28'h2040007, 1, 0, 0, 0);
    chk(lat == 3, "R4 xram 2 waits", lat, 3);
    chk(f_addr == 25'h6 && f_size == 1 && f_sel == 9'h002, "R13 half align", 32'(f_addr), 6);
    chk(rd == {16'h0, ew(25'h6)[15:0]}, "R13 half zero-extend", rd, {16'h0, ew(25'h6)[15:0]});
    xram_fast = 1;
    do_req(28'h2000006, 1, 0, 0, 0);
    chk(lat == 2, "R4 xram fast", lat, 2);
    xram_fast = 0;
    do_req(28'h2000007, 2, 0, 0, 0);
    chk(lat == 6, "R7 split latency", lat, 6);
    chk(f_addr == 25'h4 && l_addr == 25'h6, "R7 split offsets", {7'h0, f_addr}, {7'h0, 25'h4});
    chk(rd == {ew(25'h6)[15:0], ew(25'h4)[15:0]}, "R7 split data", rd, {ew(25'h6)[15:0], ew(25'h4)[15:0]});
    xram_fast = 1;
    do_req(28'h2000010, 2, 1, 0, 32'h1234ABCD);
    chk(lat == 4, "R7 split fast latency", lat, 4);
    chk(f_wd[15:0] == 16'hABCD && l_wd[15:0] == 16'h1234 && saw_we, "R7 write halves", {f_wd[15:0], l_wd[15:0]}, 32'hABCD1234);
    xram_fast = 0;
  endtask

  task automatic t_video;
    disp_busy = 0;
    do_req(28'h5000402, 1, 0, 0, 0);
    chk(lat == 1 && f_addr == 25'h2 && f_sel == 9'h010, "R5 colour idle", lat, 1);
    disp_busy = 1;
    do_req(28'h5000402, 1, 0, 0, 0);
    chk(lat == 2, "R5 colour busy", lat, 2);
    do_req(28'h7000010, 2, 0, 0, 0);
    chk(lat == 2 && f_sel == 9'h040, "R5 sprite busy word", lat, 2);
    do_req(28'h6000020, 2, 0, 0, 0);
    chk(lat == 4, "R5 picture split busy", lat, 4);
    disp_busy = 0;
    do_req(28'h6018010, 1, 0, 0, 0);
    chk(f_addr == 25'h10010 && f_sel == 9'h020, "R1 picture fold", 32'(f_addr), 32'h10010);
  endtask

  task automatic t_cart;
    wait_cfg = 14'h3927;
    do_req(28'h8000100, 1, 0, 0, 0);
    chk(lat == 4 && f_sel == 9'h080, "R6 win0 random", lat, 4);
    do_req(28'h8000100, 1, 0, 1, 0);
    chk(lat == 2, "R6 win0 follow-on", lat, 2);
    do_req(28'h9000100, 1, 0, 0, 0);
    chk(f_addr == 25'h1000100 && lat == 4, "R1 cart upper half", 32'(f_addr), 32'h1000100);
    do_req(28'hA000100, 1, 0, 0, 0);
    chk(lat == 3, "R6 win1 random", lat, 3);
    do_req(28'hC000100, 2, 0, 0, 0);
    chk(lat == 5 && l_addr == 25'h102, "R7 win2 split second follow-on", lat, 5);
    do_req(28'hB000100, 2, 0, 1, 0);
    chk(lat == 2, "R6 win1 split follow-on", lat, 2);
  endtask

  task automatic t_save;
    wait_cfg = 14'h3927;
    do_req(28'hE000103, 2, 0, 0, 0);
    chk(lat == 4 && f_size == 0 && f_sel == 9'h100, "R8 save byte", lat, 4);
    chk(f_addr == 25'h103 && sel_cyc == 4, "R8 save exact byte", 32'(f_addr), 32'h103);
    chk(rd == {24'h0, ew(25'h103)[7:0]}, "R8 save data", rd, {24'h0, ew(25'h103)[7:0]});
    do_req(28'hE010005, 1, 0, 0, 0);
    chk(f_addr == 25'h5, "R1 save wrap", 32'(f_addr), 5);
  endtask

  task automatic t_unmapped;
    do_req(28'h1000000, 2, 0, 0, 0);
    chk(err && lat == 0 && rd == 0 && sel_cyc == 0, "R10 slot1", {31'h0, err}, 1);
    do_req(28'h4000400, 1, 0, 0, 0);
    chk(err && sel_cyc == 0, "R10 io beyond", {31'h0, err}, 1);
    do_req(28'hF000000, 0, 0, 0, 0);
    chk(err && rd == 0, "R10 slotF", rd, 0);
  endtask

  task automatic t_busy_ignore;
    int n;
    wait_cfg = 14'h3927;
    @(negedge clk);
    req_valid = 1; req_addr = 28'h8000100; req_size = 1; req_write = 0; req_seq = 0;
    @(posedge clk);
    @(negedge clk);
    req_addr = 28'h1000000;
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!resp_ready && n < 20) begin @(negedge clk); n++; end
    chk(resp_ready && !resp_err, "R11 in-flight request ignored", {31'h0, resp_err}, 0);
    n = 0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (resp_ready) n++; end
    chk(n == 0, "R11 no second response", n, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 0;
    t_zero_wait();
    t_boot_guard();
    t_xram();
    t_video();
    t_cart();
    t_save();
    t_unmapped();
    t_busy_ignore();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule